// File: doc/BRIEF.md
# Carrier Sum Mixer

This block turns the stream of operator results from a four-operator, six-voice synthesis pipeline into one 9-bit signed sample per voice per frame, sized for a low-resolution DAC. A frame is 24 slots, one per clock. Slot k carries voice k mod 6 and operator group (k div 6) mod 4, so all six voices are visited once per group. The block drives a marker on the first slot of every frame so that the upstream pipeline can stay aligned with it.

In each slot the 14-bit signed operator value is reduced to 9 bits by an arithmetic shift right of 5, with no rounding. If the slot is flagged as a carrier, the reduced value is added to that voice's running total. The running totals are kept in a six-deep rotating shift register, so the voice being served is always at the head. The adder is 9 bits wide and clamps the result instead of wrapping. In the final group the voice's total is driven out and its stored total is cleared. The last voice can instead output a value supplied from outside when direct mode is enabled for it.

Top module: `carrier_mixer`

## Requirements
- R1: While reset is asserted, and until the first emission, `smp_valid` is 0 and `smp_value` is 0. The first slot after reset is slot 0, and `frame_start` is 1 in that slot.
- R2: Slot k serves voice k mod 6 and group (k div 6) mod 4. `frame_start` is 1 exactly when k mod 24 is 0.
- R3: The operator value is reduced to 9 bits as floor(value / 32). For example, -1 becomes -1, and +1 to +31 become 0.
- R4: The reduced value is added to the voice's total only when `op_carrier` is 1. Slots that are not carriers leave the total unchanged.
- R5: Each addition clamps to the range -256 to +255. Four carriers at +8191 give +255, and four at -8192 give -256.
- R6: One clock after a slot of group 3, `smp_valid` is 1, `smp_chan` carries that slot's voice (0..5), and `smp_value` carries the total. In every other cycle `smp_valid`, `smp_chan` and `smp_value` are 0.
- R7: A voice's total is cleared when it is emitted, so each frame starts from 0. A voice with no carriers emits 0.
- R8: When `dac_en` is 1 during the group-3 slot of voice 5, `dac_value` is emitted in place of the total. `dac_en` has no effect in any other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| op_value | input | 14 | Signed operator result for the current slot |
| op_carrier | input | 1 | Current slot's operator is a carrier |
| dac_en | input | 1 | Direct mode for voice 5 |
| dac_value | input | 9 | Signed direct sample for voice 5 |
| frame_start | output | 1 | Current slot is slot 0 of a frame |
| smp_valid | output | 1 | Sample emitted this cycle |
| smp_chan | output | 3 | Voice of the emitted sample |
| smp_value | output | 9 | Signed emitted sample |

## Verification
Every stored total is consumed within one frame. As a result, a corrupted head entry, a shift register that drifts out of alignment, or a clear that is missed shows up as a wrong `smp_value` no later than 24 cycles after the fault. A missed clear appears as a wrong `smp_value` in the following frame. A miscounted slot or group shows up at once, either as a marker in the wrong place or as a sample on the wrong voice. Sign handling is exposed by negative values that are smaller in magnitude than 32, and clamping is exposed by frames where the values sit at full scale.

// File: rtl/carrier_mixer.sv
module carrier_mixer #(
  parameter int IN_W   = 14,
  parameter int OUT_W  = 9,
  parameter int NCH    = 6,
  parameter int NOPS   = 4,
  parameter int DAC_CH = NCH - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [IN_W-1:0]  op_value,
  input  logic                    op_carrier,
  input  logic                    dac_en,
  input  logic signed [OUT_W-1:0] dac_value,
  output logic                    frame_start,
  output logic                    smp_valid,
  output logic [2:0]              smp_chan,
  output logic signed [OUT_W-1:0] smp_value
);
  localparam int SHIFT = IN_W - OUT_W;
  localparam int CW    = 3;
  localparam int GW    = $clog2(NOPS);
  localparam logic signed [OUT_W-1:0] TOP = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] BOT = {1'b1, {(OUT_W-1){1'b0}}};

  logic [CW-1:0] ch_q;
  logic [GW-1:0] grp_q;
  logic signed [OUT_W-1:0] part_sr [NCH];

  wire signed [OUT_W-1:0] op_red = op_value[IN_W-1:SHIFT];
  wire signed [OUT_W:0]   wide   = {part_sr[0][OUT_W-1], part_sr[0]} + {op_red[OUT_W-1], op_red};
  wire                    ovf    = wide[OUT_W] != wide[OUT_W-1];
  wire signed [OUT_W-1:0] clip   = ovf ? (wide[OUT_W] ? BOT : TOP) : wide[OUT_W-1:0];
  wire signed [OUT_W-1:0] sum_now = op_carrier ? clip : part_sr[0];
  wire last_slot = grp_q == GW'(NOPS - 1);
  wire last_ch   = ch_q == CW'(NCH - 1);

  assign frame_start = (ch_q == '0) && (grp_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q      <= '0;
      grp_q     <= '0;
      smp_valid <= 1'b0;
      smp_chan  <= '0;
      smp_value <= '0;
      for (int i = 0; i < NCH; i++) part_sr[i] <= '0;
    end else begin
      for (int i = 0; i < NCH - 1; i++) part_sr[i] <= part_sr[i+1];
      part_sr[NCH-1] <= last_slot ? '0 : sum_now;
      if (last_ch) begin
        ch_q  <= '0;
        grp_q <= last_slot ? '0 : grp_q + 1'b1;
      end else begin
        ch_q <= ch_q + 1'b1;
      end
      smp_valid <= last_slot;
      smp_chan  <= last_slot ? ch_q : '0;
      if (!last_slot)
        smp_value <= '0;
      else if (ch_q == CW'(DAC_CH) && dac_en)
        smp_value <= dac_value;
      else
        smp_value <= sum_now;
    end
  end
endmodule

module carrier_mixer_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              dac_en,
  input logic signed [8:0] dac_value,
  input logic              frame_start,
  input logic              smp_valid,
  input logic [2:0]        smp_chan,
  input logic signed [8:0] smp_value
);
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> (smp_value == 9'sd0 && smp_chan == 3'd0));
  assert_chan_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> smp_chan <= 3'd5);
  assert_chan_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_chan != 3'd5) |=> (smp_valid && smp_chan == 3'($past(smp_chan) + 3'd1)));
  assert_marker_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  assert_marker_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_chan == 3'd5) |-> frame_start);
  assert_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_chan == 3'd5 && $past(dac_en) && $past(rst_n)) |-> smp_value == $past(dac_value));
endmodule

bind carrier_mixer carrier_mixer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .dac_en(dac_en), .dac_value(dac_value),
  .frame_start(frame_start), .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_value(smp_value)
);

// File: tb/carrier_mixer_tb.sv
module carrier_mixer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAMES = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [13:0] op_value = '0;
  logic op_carrier = 1'b0;
  logic dac_en = 1'b0;
  logic signed [8:0] dac_value = '0;
  logic frame_start, smp_valid;
  logic [2:0] smp_chan;
  logic signed [8:0] smp_value;

  int checks = 0, fails = 0, cyc = 0;
  int sums [6];
  int exp_valid = 0, exp_chan = 0, exp_val = 0;
  string exp_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  carrier_mixer dut_i (
    .clk(clk), .rst_n(rst_n), .op_value(op_value), .op_carrier(op_carrier),
    .dac_en(dac_en), .dac_value(dac_value), .frame_start(frame_start),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_value(smp_value)
  );

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int clamp(int v);
    if (v > 255) return 255;
    if (v < -256) return -256;
    return v;
  endfunction

  initial begin
    for (int i = 0; i < 6; i++) sums[i] = 0;
    repeat (3) @(negedge clk);
    check("R1", smp_valid, 0, "valid in reset");
    check("R1", smp_value, 0, "value in reset");
    rst_n = 1'b1;
    for (int k = 0; k < FRAMES * 24; k++) begin
      int ch, grp, fr, v, red;
      logic signed [13:0] ov;
      logic car;
      ch = k % 6; grp = (k / 6) % 4; fr = k / 24;
      if (k > 0) @(negedge clk);
      check(k == 0 ? "R1" : "R2", frame_start, (k % 24 == 0) ? 1 : 0, "frame_start");
      check(exp_tag, smp_valid, exp_valid, "smp_valid");
      if (exp_valid != 0) check(exp_tag, smp_chan, exp_chan, "smp_chan");
      check(exp_tag, smp_value, exp_val, "smp_value");
      ov = 14'($urandom);
      car = 1'($urandom);
      dac_en = 1'($urandom);
      dac_value = 9'($urandom);
      if (fr == 0) begin
        case (ch)
          0: begin car = (grp == 0); ov = (grp == 0) ? -14'sd1 : 14'sd8000; end
          1: begin car = 1'b1; ov = 14'sd31; end
          2: begin car = 1'b1; ov = 14'sd8191; end
          3: begin car = 1'b1; ov = -14'sd8192; end
          4: car = 1'b0;
          default: begin car = (grp == 1); ov = 14'sd4000; dac_en = (grp == 3); dac_value = -9'sd77; end
        endcase
      end else if (fr % 3 == 0) begin
        ov = $urandom_range(0, 1) ? 14'sd8191 : -14'sd8192;
      end else if (fr % 3 == 1) begin
        ov = 14'($signed($urandom_range(0, 63)) - 32);
      end
      op_value = ov; op_carrier = car;
      v = ov;
      red = v >>> 5;
      if (car) sums[ch] = clamp(sums[ch] + red);
      if (grp == 3) begin
        exp_valid = 1; exp_chan = ch;
        exp_val = (ch == 5 && dac_en) ? int'(dac_value) : sums[ch];
        sums[ch] = 0;
        if (fr == 0)
          exp_tag = (ch == 0) ? "R3" : (ch == 1) ? "R3" : (ch < 4) ? "R5" : (ch == 4) ? "R4" : "R8";
        else if (fr == 1) exp_tag = "R7";
        else exp_tag = "R6";
      end else begin
        exp_valid = 0; exp_chan = 0; exp_val = 0;
        exp_tag = "R6";
      end
      @(posedge clk);
    end
    @(negedge clk);
    check(exp_tag, smp_valid, exp_valid, "smp_valid");
    check(exp_tag, smp_value, exp_val, "smp_value");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule